// File: doc/BRIEF.md
# Paired-Instruction Fetch Sequencer

This block feeds instructions to the execution stage of a stored-program machine whose memory words are 40 bits wide and each carry two 20-bit instructions. It addresses memory from its own pair counter through a registered address register, captures the returned word in a buffer register, and then issues the two halves one after the other over a valid/ready handshake. The half that issues second is kept in a local instruction buffer, so each memory read feeds two issued instructions. The counter therefore counts word (pair) addresses, not instructions.

Each issued instruction is presented as an 8-bit opcode, held in the instruction register, and a 12-bit operand address on its own output. Execution can redirect the stream with a jump request. The request carries a 12-bit pair address and a select bit that says whether execution resumes at the left or the right half of that word. The memory side is a simple one-cycle request with a later read-valid response. Only one read is outstanding at a time.

Top module: `pair_fetch_seq`

## Requirements
- R1: The half in bits 39:20 of a fetched word issues first and the half in bits 19:0 issues next. In each instruction the opcode is bits 19:12 (output on the opcode port) and the operand address is bits 11:0 (output on the operand port).
- R2: The second half of a word issues from the local buffer without a further memory read. It is presented in the cycle right after the first half is accepted. Exactly one read is made per word issued.
- R3: The pair counter advances by one per word read, so sequential words are requested at consecutive addresses, and address 4095 is followed by address 0.
- R4: While an instruction is presented and not accepted, valid stays high and the opcode and operand do not change.
- R5: No memory request is made while an instruction is presented, and valid stays low from a request until that request's data has been split.
- R6: A jump with the select bit at 0 loads the target pair address, drops any buffered half and valid in the next cycle, and then issues the target word's left half, its right half, then the next word.
- R7: A jump with the select bit at 1 issues the target word's right half first, followed by the left half of the following word.
- R8: A jump made while a read is outstanding discards that read's data. The stream then resumes at the jump target.
- R9: A synchronous reset clears the pair counter and the buffered half and withdraws valid. After reset the first read is to address 0, even if reset came while a buffered half was pending.
- R10: A memory request is a single-cycle pulse, with the address taken from the address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_req_o | output | 1 | Single-cycle read request |
| mem_addr_o | output | 12 | Word address from the address register |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 40 | Read data word |
| jump_i | input | 1 | Redirect request from execution |
| jump_addr_i | input | 12 | Target pair address |
| jump_right_i | input | 1 | 1: resume at the right half of the target |
| insn_valid_o | output | 1 | An instruction is presented |
| insn_ready_i | input | 1 | Execution accepts the presented instruction |
| insn_opcode_o | output | 8 | Opcode of the presented instruction |
| insn_operand_o | output | 12 | Operand address of the presented instruction |

## Verification
Every memory word is a distinct arithmetic function of its address, so any wrong half, wrong order or wrong word shows up in the issued values. A sequential sweep over forty words mixes memory latencies of one to three cycles with consumer stalls of zero to two cycles. The stalls separate correct holding from premature advance, and the read count at each second-half issue separates buffered issue from refetching. A jump sweep over sixteen scattered targets alternates the two select values. Extra cases place a jump one or two cycles into an outstanding read, jump to the last address to reach the wrap, and apply reset with a buffered half pending.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
    typedef enum logic [2:0] {
        ST_START   = 3'd0,
        ST_REQ     = 3'd1,
        ST_WAIT    = 3'd2,
        ST_SPLIT   = 3'd3,
        ST_PRESENT = 3'd4
    } fetch_st_e;
endpackage

// File: rtl/pfs_pair_counter.sv
module pfs_pair_counter #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] pc_o
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] pc_d, pc_q;

    always_comb begin
        pc_d = pc_q;
        if (load) begin
            pc_d = load_addr;
        end else if (step) begin
            pc_d = pc_q + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign pc_o = pc_q;
endmodule

// File: rtl/pfs_half_sel.sv
module pfs_half_sel #(
    parameter int INSN_W = 20
) (
    input  logic [2*INSN_W-1:0] word_i,
    input  logic                pick_right_i,
    output logic [INSN_W-1:0]   insn_o
);
    assign insn_o = pick_right_i ? word_i[INSN_W-1:0] : word_i[2*INSN_W-1:INSN_W];
endmodule

// File: rtl/pair_fetch_seq.sv
module pair_fetch_seq #(
    parameter int OPC_W  = 8,
    parameter int ADDR_W = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    output logic                      mem_req_o,
    output logic [ADDR_W-1:0]         mem_addr_o,
    input  logic                      mem_rvalid_i,
    input  logic [2*(OPC_W+ADDR_W)-1:0] mem_rdata_i,
    input  logic                      jump_i,
    input  logic [ADDR_W-1:0]         jump_addr_i,
    input  logic                      jump_right_i,
    output logic                      insn_valid_o,
    input  logic                      insn_ready_i,
    output logic [OPC_W-1:0]          insn_opcode_o,
    output logic [ADDR_W-1:0]         insn_operand_o
);
    import pfs_pkg::*;

    localparam int INSN_W = OPC_W + ADDR_W;
    localparam int WORD_W = 2 * INSN_W;

    typedef struct packed {
        fetch_st_e         st;
        logic [ADDR_W-1:0] mar;
        logic [WORD_W-1:0] mbr;
        logic [INSN_W-1:0] ibr;
        logic              ibr_v;
        logic [OPC_W-1:0]  ir;
        logic [ADDR_W-1:0] opnd;
        logic              start_right;
        logic              discard;
    } seq_t;

    seq_t r_d, r_q;

    logic              pc_load, pc_step;
    logic [ADDR_W-1:0] pc;
    logic [INSN_W-1:0] first_insn;

    pfs_pair_counter #(.ADDR_W(ADDR_W)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .load     (pc_load),
        .load_addr(jump_addr_i),
        .step     (pc_step),
        .pc_o     (pc)
    );

    pfs_half_sel #(.INSN_W(INSN_W)) u_sel (
        .word_i      (r_q.mbr),
        .pick_right_i(r_q.start_right),
        .insn_o      (first_insn)
    );

    always_comb begin
        r_d     = r_q;
        pc_load = 1'b0;
        pc_step = 1'b0;

        case (r_q.st)
            ST_START: begin
                r_d.mar = pc;
                pc_step = 1'b1;
                r_d.st  = ST_REQ;
            end
            ST_REQ: begin
                r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rvalid_i) begin
                    if (r_q.discard) begin
                        r_d.discard = 1'b0;
                        r_d.st      = ST_START;
                    end else begin
                        r_d.mbr = mem_rdata_i;
                        r_d.st  = ST_SPLIT;
                    end
                end
            end
            ST_SPLIT: begin
                {r_d.ir, r_d.opnd} = first_insn;
                r_d.ibr            = r_q.mbr[INSN_W-1:0];
                r_d.ibr_v          = !r_q.start_right;
                r_d.start_right    = 1'b0;
                r_d.st             = ST_PRESENT;
            end
            ST_PRESENT: begin
                if (insn_ready_i) begin
                    if (r_q.ibr_v) begin
                        {r_d.ir, r_d.opnd} = r_q.ibr;
                        r_d.ibr_v          = 1'b0;
                    end else begin
                        r_d.st = ST_START;
                    end
                end
            end
            default: r_d.st = ST_START;
        endcase

        // Redirect wins over everything above; a read already issued must drain.
        if (jump_i) begin
            pc_load         = 1'b1;
            pc_step         = 1'b0;
            r_d.ibr_v       = 1'b0;
            r_d.start_right = jump_right_i;
            if (r_q.st == ST_REQ || (r_q.st == ST_WAIT && !mem_rvalid_i)) begin
                r_d.st      = ST_WAIT;
                r_d.discard = 1'b1;
            end else begin
                r_d.st      = ST_START;
                r_d.discard = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req_o      = (r_q.st == ST_REQ);
    assign mem_addr_o     = r_q.mar;
    assign insn_valid_o   = (r_q.st == ST_PRESENT);
    assign insn_opcode_o  = r_q.ir;
    assign insn_operand_o = r_q.opnd;
endmodule

// File: rtl/pfs_chk.sv
module pfs_chk #(
    parameter int OPC_W  = 8,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              insn_valid,
    input logic              insn_ready,
    input logic              jump,
    input logic [OPC_W-1:0]  opcode,
    input logic [ADDR_W-1:0] operand,
    input logic              ibr_v
);
    // R4
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        insn_valid && !insn_ready && !jump |=> insn_valid && $stable(opcode) && $stable(operand));

    // R5
    no_req_when_valid_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !insn_valid);

    // R5
    wait_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !insn_valid);

    // R10
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R2
    buffered_issue_chk: assert property (@(posedge clk) disable iff (rst)
        insn_valid && insn_ready && !jump && ibr_v |=> insn_valid && !mem_req);

    // R6
    jump_drop_chk: assert property (@(posedge clk) disable iff (rst)
        jump |=> !insn_valid);

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> !insn_valid && !mem_req);
endmodule

bind pair_fetch_seq pfs_chk #(.OPC_W(OPC_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req_o),
    .insn_valid(insn_valid_o),
    .insn_ready(insn_ready_i),
    .jump      (jump_i),
    .opcode    (insn_opcode_o),
    .operand   (insn_operand_o),
    .ibr_v     (r_q.ibr_v)
);

// File: tb/pair_fetch_seq_tb.sv
module pair_fetch_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_req_o;
    logic [11:0] mem_addr_o;
    logic        mem_rvalid_i = 1'b0;
    logic [39:0] mem_rdata_i = '0;
    logic        jump_i = 1'b0;
    logic [11:0] jump_addr_i = '0;
    logic        jump_right_i = 1'b0;
    logic        insn_valid_o;
    logic        insn_ready_i = 1'b0;
    logic [7:0]  insn_opcode_o;
    logic [11:0] insn_operand_o;

    int total = 0;
    int bad = 0;
    int reads = 0;
    int lat = 1;
    int cnt = 0;
    logic [11:0] req_addr = '0;
    bit done = 0;

    always #2 clk = ~clk;

    pair_fetch_seq u_dut (
        .clk(clk), .rst(rst),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
        .jump_i(jump_i), .jump_addr_i(jump_addr_i), .jump_right_i(jump_right_i),
        .insn_valid_o(insn_valid_o), .insn_ready_i(insn_ready_i),
        .insn_opcode_o(insn_opcode_o), .insn_operand_o(insn_operand_o)
    );

    function automatic logic [39:0] wd(input logic [11:0] a);
        logic [7:0] o1 = 8'(a * 3 + 12'h011);
        logic [7:0] o2 = 8'(a * 5 + 12'h040);
        return {o1, a ^ 12'hA5C, o2, ~a};
    endfunction

    // memory model, driven away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            cnt = 0;
            mem_rvalid_i = 1'b0;
        end else begin
            mem_rvalid_i = 1'b0;
            if (cnt > 0) begin
                cnt = cnt - 1;
                if (cnt == 0) begin
                    mem_rvalid_i = 1'b1;
                    mem_rdata_i  = wd(req_addr);
                end
            end
            if (mem_req_o) begin
                cnt = lat;
                req_addr = mem_addr_o;
                reads = reads + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic take(input logic [19:0] exp, input string req, input int stall);
        int g = 0;
        logic [19:0] held;
        while (!insn_valid_o && g < 2000) begin
            @(negedge clk);
            g++;
        end
        held = {insn_opcode_o, insn_operand_o};
        repeat (stall) @(negedge clk);
        if (stall > 0)
            check(insn_valid_o && held == {insn_opcode_o, insn_operand_o}, "R4 hold",
                  {insn_valid_o, insn_opcode_o, insn_operand_o}, {1'b1, held});
        check(insn_valid_o && {insn_opcode_o, insn_operand_o} == exp, req,
              {insn_valid_o, insn_opcode_o, insn_operand_o}, {1'b1, exp});
        insn_ready_i = 1'b1;
        @(negedge clk);
        insn_ready_i = 1'b0;
    endtask

    task automatic do_jump(input logic [11:0] a, input logic right);
        insn_ready_i = 1'b0;
        jump_i = 1'b1;
        jump_addr_i = a;
        jump_right_i = right;
        @(negedge clk);
        jump_i = 1'b0;
        check(!insn_valid_o, "R6 valid dropped after jump", insn_valid_o, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base;
        logic [11:0] t;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(!insn_valid_o && !mem_req_o, "R9 idle in reset", {insn_valid_o, mem_req_o}, 0);
        rst = 1'b0;
        while (reads == 0) @(negedge clk);
        check(req_addr == 12'd0, "R9 first read address", req_addr, 0);

        // sequential sweep: R1 R2 R3 R5
        base = 0;
        for (int j = 0; j < 40; j++) begin
            lat = 1 + (j % 3);
            take(wd(12'(j))[39:20], "R1 left half first", j % 3);
            check(insn_valid_o, "R2 right half immediately valid", insn_valid_o, 1);
            check(reads == base + j + 1, "R2 one read per word", reads, base + j + 1);
            take(wd(12'(j))[19:0], "R1 right half second", (j + 1) % 3);
        end
        check(req_addr == 12'd40 || req_addr == 12'd39, "R3 sequential addresses", req_addr, 40);

        // jump sweep: R6 R7
        lat = 2;
        for (int i = 0; i < 16; i++) begin
            t = 12'((i * 331 + 7) % 4096);
            do_jump(t, i[0]);
            if (!i[0]) begin
                take(wd(t)[39:20], "R6 target left", 0);
                take(wd(t)[19:0], "R6 target right", i % 3);
                take(wd(t + 12'd1)[39:20], "R6 following word", 0);
            end else begin
                take(wd(t)[19:0], "R7 target right first", 0);
                take(wd(t + 12'd1)[39:20], "R7 next word left", i % 3);
                take(wd(t + 12'd1)[19:0], "R7 next word right", 0);
            end
        end

        // jump during outstanding read: R8
        for (int d = 1; d <= 2; d++) begin
            lat = 3;
            do_jump(12'd100, 1'b0);
            take(wd(12'd100)[39:20], "R8 setup", 0);
            take(wd(12'd100)[19:0], "R8 setup", 0);
            repeat (d) @(negedge clk);
            do_jump(12'(200 + d), 1'b0);
            take(wd(12'(200 + d))[39:20], "R8 resumes at target", 0);
            take(wd(12'(200 + d))[19:0], "R8 target right", 0);
        end

        // wrap: R3
        lat = 1;
        do_jump(12'd4095, 1'b0);
        take(wd(12'd4095)[39:20], "R3 last word left", 0);
        take(wd(12'd4095)[19:0], "R3 last word right", 0);
        take(wd(12'd0)[39:20], "R3 wrap to 0", 0);
        take(wd(12'd0)[19:0], "R3 wrap right", 0);

        // mid-run reset with buffered half pending: R9
        take(wd(12'd1)[39:20], "R9 pre-reset", 0);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(!insn_valid_o, "R9 valid withdrawn", insn_valid_o, 0);
        rst = 1'b0;
        take(wd(12'd0)[39:20], "R9 restart at word 0", 0);
        check(req_addr == 12'd0, "R10 request address", req_addr, 0);
        take(wd(12'd0)[19:0], "R9 restart right", 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule